// File: doc/BRIEF.md
# Instruction Address Map Translator

This block turns a logical byte offset in instruction space into a physical address. The logical space is split into fixed-size blocks, one for each map register. The default has two blocks of 128 KB each. Each map register is a 16-bit word. Two of its fields matter: a 2-bit space selector and a 7-bit segment number. Together they decide where the block lands: in unified memory, in on-chip instruction memory, or in a small test window that wraps around. Translation is purely combinational.

With each offset the caller gives a requested transfer length. The block returns the length that may be moved without crossing the end of the logical block. In test mode the length is also cut at the edge of the test window. A fault output flags offsets beyond the last block and mappings that name the reserved space.

The map registers are written and read as 16-bit words through a simple register port at fixed data addresses. A build parameter picks one of two reset profiles: a hard-reset profile and a ROM-initialised profile.

Top module: `imap_xlate`

## Requirements
- R1: An offset below 131072 is translated through map word 0, and an offset from 131072 up to 262143 through map word 1. An offset of 262144 or more gives fault=1, length 0 and physical address 0.
- R2: When there is no fault, the returned length is the smaller of the requested length and (131072 − in-block offset). In test mode a further limit applies (R6).
- R3: Only map word bits 13:12 (space) and bits 6:0 (segment) affect translation. All other bits are stored but ignored.
- R4: Space 00 gives physical = 0x00000000 + (segment × 2^17) + in-block offset, with no fault.
- R5: Space 01 gives physical = 0x01000000 + 131072 × word index + in-block offset. The segment is ignored and there is no fault.
- R6: Space 11 gives physical = 0x01000000 + (in-block offset mod 2048). The length is further limited to 2048 − (in-block offset mod 2048). There is no fault.
- R7: Space 10 gives fault=1, length 0 and physical address 0.
- R8: A write with wr_en=1 to address 0xFF00 or 0xFF02 replaces map word 0 or 1 at the next clock edge. A read at those addresses returns the word. Writes to any other address, or writes with wr_en=0, change nothing. Reads of other addresses return 0.
- R9: With BOOT_PROFILE=0, reset loads word 0 with 0x0000 and word 1 with 0x007F. With BOOT_PROFILE=1, reset loads both words with 0x1000.
- R10: Physical address, length and fault follow the offset and length inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for map register writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Map register write strobe |
| wr_addr | input | 16 | Data address of the write |
| wr_data | input | 16 | Word to write |
| rd_addr | input | 16 | Data address to read back |
| rd_data | output | 16 | Map word at rd_addr, or 0 |
| log_ofs | input | 32 | Logical instruction byte offset |
| req_len | input | 18 | Requested transfer length in bytes |
| phys_addr | output | 32 | Translated physical address |
| xfer_len | output | 18 | Bytes allowed before the boundary |
| xlat_fault | output | 1 | Out of range or reserved space |

## Verification
The hardest case to reach is test mode near the end of a block. There, both the block limit and the wrap of the test window cut the length. To reach it, the stimulus first rewrites a map word to space 11 through the register port. It then probes offsets a few bytes below a 2048-byte edge and a few bytes below the block end. A random phase follows: it mixes map writes of arbitrary words, including the reserved space and stray high bits, with offsets that run past the last block. A behavioural model checks every probe.

// File: rtl/imap_pkg.sv
package imap_pkg;

  localparam int MAP_W = 16;
  localparam int SEG_W = 7;

  typedef enum logic [1:0] {
    SP_UNIFIED = 2'b00,
    SP_INSN    = 2'b01,
    SP_RSVD    = 2'b10,
    SP_TEST    = 2'b11
  } space_e;

  function automatic space_e map_space(input logic [MAP_W-1:0] w);
    return space_e'(w[13:12]);
  endfunction

  function automatic logic [SEG_W-1:0] map_seg(input logic [MAP_W-1:0] w);
    return w[SEG_W-1:0];
  endfunction

endpackage

// File: rtl/imap_regs.sv
module imap_regs #(
  parameter int          NUM_MAP      = 2,
  parameter int          BOOT_PROFILE = 0,
  parameter logic [15:0] MAP_BASE     = 16'hFF00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [15:0]                 wr_addr,
  input  logic [15:0]                 wr_data,
  input  logic [15:0]                 rd_addr,
  output logic [15:0]                 rd_data,
  output logic [NUM_MAP-1:0][15:0]    map_q
);

  logic [NUM_MAP-1:0][15:0] map_d;

  for (genvar i = 0; i < NUM_MAP; i++) begin : g_word
    localparam logic [15:0] WORD_ADDR = MAP_BASE + 16'(2 * i);
    localparam logic [15:0] RST_VAL   = (BOOT_PROFILE != 0) ? 16'h1000 :
                                        (i == 1)            ? 16'h007F : 16'h0000;
    logic hit;

    assign hit = wr_en && (wr_addr == WORD_ADDR);

    always_comb begin
      map_d[i] = map_q[i];
      if (hit) map_d[i] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_q[i] <= RST_VAL;
      else        map_q[i] <= map_d[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_MAP; i++) begin
      if (rd_addr == MAP_BASE + 16'(2 * i)) rd_data = map_q[i];
    end
  end

endmodule

// File: rtl/imap_space_xlate.sv
module imap_space_xlate
  import imap_pkg::*;
#(
  parameter int              PA_W      = 32,
  parameter int              BOFS_W    = 17,
  parameter int              LEN_W     = 18,
  parameter int              BLK_BYTES = 131072,
  parameter int              SEG_SHIFT = 17,
  parameter int              TEST_WIN  = 2048,
  parameter int              IDX       = 0,
  parameter logic [PA_W-1:0] UNI_BASE  = '0,
  parameter logic [PA_W-1:0] INS_BASE  = '0
) (
  input  logic [MAP_W-1:0]  map_word,
  input  logic [BOFS_W-1:0] blk_ofs,
  input  logic [LEN_W-1:0]  req_len,
  output logic [PA_W-1:0]   phys,
  output logic [LEN_W-1:0]  len,
  output logic              fault
);

  localparam int              TW_W     = $clog2(TEST_WIN);
  localparam logic [PA_W-1:0] REG_BASE = INS_BASE + PA_W'(IDX) * PA_W'(BLK_BYTES);

  space_e          space;
  logic [SEG_W-1:0] seg;
  logic [LEN_W-1:0] blk_room, blk_len, win_room;
  logic [TW_W-1:0]  win_ofs;
  logic             unused_map_bits;

  assign space           = map_space(map_word);
  assign seg             = map_seg(map_word);
  assign unused_map_bits = ^{map_word[15:14], map_word[11:SEG_W]};

  assign blk_room = LEN_W'(BLK_BYTES) - LEN_W'(blk_ofs);
  assign blk_len  = (req_len < blk_room) ? req_len : blk_room;
  assign win_ofs  = blk_ofs[TW_W-1:0];
  assign win_room = LEN_W'(TEST_WIN) - LEN_W'(win_ofs);

  always_comb begin
    phys  = '0;
    len   = '0;
    fault = 1'b0;
    unique case (space)
      SP_UNIFIED: begin
        phys = UNI_BASE + (PA_W'(seg) << SEG_SHIFT) + PA_W'(blk_ofs);
        len  = blk_len;
      end
      SP_INSN: begin
        phys = REG_BASE + PA_W'(blk_ofs);
        len  = blk_len;
      end
      SP_TEST: begin
        phys = INS_BASE + PA_W'(win_ofs);
        len  = (blk_len < win_room) ? blk_len : win_room;
      end
      default: begin
        fault = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/imap_xlate.sv
module imap_xlate
  import imap_pkg::*;
#(
  parameter int              OFS_W        = 32,
  parameter int              PA_W         = 32,
  parameter int              BLK_BYTES    = 131072,
  parameter int              NUM_MAP      = 2,
  parameter int              SEG_SHIFT    = 17,
  parameter int              TEST_WIN     = 2048,
  parameter logic [PA_W-1:0] UNI_BASE     = 32'h0000_0000,
  parameter logic [PA_W-1:0] INS_BASE     = 32'h0100_0000,
  parameter logic [15:0]     MAP_BASE     = 16'hFF00,
  parameter int              BOOT_PROFILE = 0,
  localparam int             BOFS_W       = $clog2(BLK_BYTES),
  localparam int             LEN_W        = BOFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_addr,
  input  logic [15:0]      wr_data,
  input  logic [15:0]      rd_addr,
  output logic [15:0]      rd_data,
  input  logic [OFS_W-1:0] log_ofs,
  input  logic [LEN_W-1:0] req_len,
  output logic [PA_W-1:0]  phys_addr,
  output logic [LEN_W-1:0] xfer_len,
  output logic             xlat_fault
);

  localparam int IDX_W = (NUM_MAP > 1) ? $clog2(NUM_MAP) : 1;
  localparam int UP_W  = OFS_W - BOFS_W;

  logic [NUM_MAP-1:0][15:0] map_q;
  logic [UP_W-1:0]          upper;
  logic                     in_range;
  logic [IDX_W-1:0]         idx;
  logic [PA_W-1:0]          lane_pa    [NUM_MAP];
  logic [LEN_W-1:0]         lane_len   [NUM_MAP];
  logic                     lane_fault [NUM_MAP];

  imap_regs #(
    .NUM_MAP      (NUM_MAP),
    .BOOT_PROFILE (BOOT_PROFILE),
    .MAP_BASE     (MAP_BASE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .map_q   (map_q)
  );

  for (genvar i = 0; i < NUM_MAP; i++) begin : g_lane
    imap_space_xlate #(
      .PA_W      (PA_W),
      .BOFS_W    (BOFS_W),
      .LEN_W     (LEN_W),
      .BLK_BYTES (BLK_BYTES),
      .SEG_SHIFT (SEG_SHIFT),
      .TEST_WIN  (TEST_WIN),
      .IDX       (i),
      .UNI_BASE  (UNI_BASE),
      .INS_BASE  (INS_BASE)
    ) u_lane (
      .map_word (map_q[i]),
      .blk_ofs  (log_ofs[BOFS_W-1:0]),
      .req_len  (req_len),
      .phys     (lane_pa[i]),
      .len      (lane_len[i]),
      .fault    (lane_fault[i])
    );
  end

  assign upper    = log_ofs[OFS_W-1:BOFS_W];
  assign in_range = upper < UP_W'(NUM_MAP);
  assign idx      = upper[IDX_W-1:0];

  always_comb begin
    phys_addr  = '0;
    xfer_len   = '0;
    xlat_fault = 1'b1;
    if (in_range) begin
      phys_addr  = lane_pa[idx];
      xfer_len   = lane_len[idx];
      xlat_fault = lane_fault[idx];
    end
  end

endmodule

// File: rtl/imap_xlate_chk.sv
module imap_xlate_chk #(
  parameter int          OFS_W     = 32,
  parameter int          PA_W      = 32,
  parameter int          BLK_BYTES = 131072,
  parameter int          NUM_MAP   = 2,
  parameter logic [15:0] MAP_BASE  = 16'hFF00,
  parameter int          BOFS_W    = 17,
  parameter int          LEN_W     = 18
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [15:0]              wr_addr,
  input logic [15:0]              wr_data,
  input logic [OFS_W-1:0]         log_ofs,
  input logic [LEN_W-1:0]         req_len,
  input logic [PA_W-1:0]          phys_addr,
  input logic [LEN_W-1:0]         xfer_len,
  input logic                     xlat_fault,
  input logic [NUM_MAP-1:0][15:0] map_q
);

  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_fault |-> (xfer_len == '0 && phys_addr == '0));

  // R1
  range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_ofs[OFS_W-1:BOFS_W] >= (OFS_W-BOFS_W)'(NUM_MAP)) |-> xlat_fault);

  // R2
  len_req_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_len <= req_len);

  // R2
  blk_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_fault |-> (int'(xfer_len) + int'(log_ofs[BOFS_W-1:0]) <= BLK_BYTES));

  // R8
  map0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MAP_BASE) |=> map_q[0] == $past(wr_data));

  // R8
  map1_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MAP_BASE + 16'd2) |=> map_q[1] == $past(wr_data));

endmodule

bind imap_xlate imap_xlate_chk #(
  .OFS_W     (OFS_W),
  .PA_W      (PA_W),
  .BLK_BYTES (BLK_BYTES),
  .NUM_MAP   (NUM_MAP),
  .MAP_BASE  (MAP_BASE),
  .BOFS_W    (BOFS_W),
  .LEN_W     (LEN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .log_ofs    (log_ofs),
  .req_len    (req_len),
  .phys_addr  (phys_addr),
  .xfer_len   (xfer_len),
  .xlat_fault (xlat_fault),
  .map_q      (map_q)
);

// File: tb/imap_xlate_bench.sv
module imap_xlate_bench;

  localparam longint BLK = 131072;
  localparam longint UNI = 64'h0000_0000;
  localparam longint INS = 64'h0100_0000;
  localparam longint WIN = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [31:0] log_ofs = '0;
  logic [17:0] req_len = '0;
  logic [15:0] rd_a, rd_b;
  logic [31:0] pa_a, pa_b;
  logic [17:0] ln_a, ln_b;
  logic        flt_a, flt_b;

  always #4 clk = ~clk;

  imap_xlate u_imap_xlate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_a), .log_ofs(log_ofs), .req_len(req_len),
    .phys_addr(pa_a), .xfer_len(ln_a), .xlat_fault(flt_a));

  imap_xlate #(.BOOT_PROFILE(1)) u_imap_xlate_rom (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_b), .log_ofs(log_ofs), .req_len(req_len),
    .phys_addr(pa_b), .xfer_len(ln_b), .xlat_fault(flt_b));

  int     n_chk = 0, n_fail = 0;
  bit     done = 1'b0;
  longint mdl_a [2] = '{64'h0000, 64'h007F};
  longint mdl_b [2] = '{64'h1000, 64'h1000};

  task automatic expect_v(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void ref_xlate(input longint mw0, input longint mw1, input longint ofs,
                                    input longint rlen, output longint pa, output longint ln,
                                    output longint flt);
    longint idx, off, mw, sp, seg, w;
    pa = 0; ln = 0; flt = 1;
    if (ofs >= 2 * BLK) return;
    idx = ofs / BLK;
    off = ofs % BLK;
    mw  = (idx == 0) ? mw0 : mw1;
    sp  = (mw >> 12) & 3;
    seg = mw & 127;
    ln  = (rlen < BLK - off) ? rlen : BLK - off;
    flt = 0;
    case (sp)
      0: pa = UNI + seg * (64'd1 << 17) + off;
      1: pa = INS + idx * BLK + off;
      3: begin
        w  = off % WIN;
        pa = INS + w;
        if (ln > WIN - w) ln = WIN - w;
      end
      default: begin pa = 0; ln = 0; flt = 1; end
    endcase
  endfunction

  task automatic probe(input longint ofs, input longint rlen, input string req);
    longint pa, ln, flt;
    @(negedge clk);
    log_ofs = 32'(ofs);
    req_len = 18'(rlen);
    #1;
    ref_xlate(mdl_a[0], mdl_a[1], ofs, rlen, pa, ln, flt);
    expect_v(req, "hard phys", longint'(pa_a), pa);
    expect_v(req, "hard len", longint'(ln_a), ln);
    expect_v(req, "hard fault", longint'(flt_a), flt);
    ref_xlate(mdl_b[0], mdl_b[1], ofs, rlen, pa, ln, flt);
    expect_v(req, "rom phys", longint'(pa_b), pa);
    expect_v(req, "rom len", longint'(ln_b), ln);
    expect_v(req, "rom fault", longint'(flt_b), flt);
  endtask

  task automatic peek(input logic [15:0] addr, input string req);
    longint ea, eb;
    @(negedge clk);
    rd_addr = addr;
    #1;
    ea = (addr == 16'hFF00) ? mdl_a[0] : (addr == 16'hFF02) ? mdl_a[1] : 0;
    eb = (addr == 16'hFF00) ? mdl_b[0] : (addr == 16'hFF02) ? mdl_b[1] : 0;
    expect_v(req, "hard readback", longint'(rd_a), ea);
    expect_v(req, "rom readback", longint'(rd_b), eb);
  endtask

  task automatic poke(input logic [15:0] addr, input logic [15:0] data, input bit en);
    @(negedge clk);
    wr_en = en; wr_addr = addr; wr_data = data;
    @(posedge clk);
    #1;
    if (en && addr == 16'hFF00) begin mdl_a[0] = data; mdl_b[0] = data; end
    if (en && addr == 16'hFF02) begin mdl_a[1] = data; mdl_b[1] = data; end
    wr_en = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset profiles
    peek(16'hFF00, "R9");
    peek(16'hFF02, "R9");
    rst_n = 1'b1;
    peek(16'hFF00, "R9");
    // R4 unified through word 0 and word 1 (segment 0x7F); R5 for ROM profile
    probe(64'h100, 16, "R4");
    probe(64'h20010, 8, "R4");
    probe(64'h20010, 8, "R5");
    // R10 outputs change within the cycle
    probe(64'h1FFF0, 64'h40, "R10");
    // R2 block clip
    probe(64'h1FFF0, 64'h40, "R2");
    probe(64'h3FFFF, 64'h3FFFF, "R2");
    probe(64'h0, 0, "R2");
    // R1 out of range
    probe(64'h40000, 4, "R1");
    probe(64'hFFFF_FFFF, 4, "R1");
    // R6 test window
    poke(16'hFF00, 16'h3000, 1'b1);
    probe(64'h1234, 64'h100, "R6");
    probe(64'h07F0, 64'h40, "R6");
    probe(64'h1FFFC, 16, "R6");
    // R7 reserved space
    poke(16'hFF00, 16'h2000, 1'b1);
    probe(64'h500, 32, "R7");
    // R8 ignored writes
    poke(16'hFF04, 16'h1111, 1'b1);
    poke(16'hFF00, 16'h1111, 1'b0);
    poke(16'hFF01, 16'h1111, 1'b1);
    peek(16'hFF00, "R8");
    peek(16'hFF02, "R8");
    peek(16'hFF04, "R8");
    probe(64'h500, 32, "R8");
    // R3 segment ignored for space 01, stray bits ignored for space 00
    poke(16'hFF02, 16'h1055, 1'b1);
    peek(16'hFF02, "R8");
    probe(64'h20400, 64'h80, "R3");
    poke(16'hFF02, 16'hCF85, 1'b1);
    probe(64'h20400, 64'h80, "R3");
    // mixed stimulus, all requirements
    for (int k = 0; k < 400; k++) begin
      if ($urandom % 4 == 0)
        poke(16'hFF00 + 16'(2 * ($urandom % 3)), 16'($urandom), 1'b1);
      probe(longint'($urandom % 32'h50000), longint'($urandom % 32'h40000), "R2");
    end
    report();
  end

endmodule